// File: doc/BRIEF.md
# Back-to-Back Operand Hazard Detector

This block decides whether an instruction issued in the current cycle depends on the instruction issued in the cycle before it. A dual-issue front end uses the result to stall the second instruction of a pair. The block does not decode instruction words. It takes decoded operand descriptors for both instructions:

- for the older instruction: whether it has a destination, the destination register, whether that destination is a memory displacement, and whether it writes the condition flag;
- for the newer instruction: a kind and a register number for each source slot, an optional displacement destination with its base register, and whether it reads the condition flag.

Memory displacement operands follow their own rules. A store's base register is checked as if it were a source. A displacement destination followed by any displacement operand always conflicts, because the store has to finish before the later memory access. Register 0 always reads as zero, so it never creates a register dependency.

The dependency signal `dep_o` is purely combinational. A registered copy, `dep_q_o`, is provided for consumers that need a flop boundary.

Top module: `issue_hazard_top`

## Requirements
- R1: When `old_wr_flag_i` and `new_rd_flag_i` are both 1, `dep_o` is 1, whatever the register operands are.
- R2: When `old_has_dst_i` is 0, `dep_o` equals `old_wr_flag_i & new_rd_flag_i`. Register operands have no effect.
- R3: A source slot whose kind is 0 (unused) or 1 (immediate) never raises `dep_o`. Slot kinds are 2 bits: 0 = unused, 1 = immediate, 2 = register direct, 3 = displacement base.
- R4: If the older destination is register direct (`old_dst_disp_i` = 0), a slot of kind 2 or 3 raises `dep_o` exactly when its register equals `old_dst_reg_i`.
- R5: When the older destination is register direct, a match on register 0 never raises `dep_o`.
- R6: If the older destination is a displacement (`old_dst_disp_i` = 1), a slot of kind 2 never raises `dep_o`.
- R7: If the older destination is a displacement, any slot of kind 3 raises `dep_o`, whatever the register numbers are (register 0 included).
- R8: When `new_dst_disp_i` = 1, the newer instruction's displacement destination is checked like a source of kind 3 with base `new_dst_reg_i`. When `new_dst_disp_i` = 0, `new_dst_reg_i` has no effect.
- R9: `dep_o` reflects the inputs of the same cycle. `dep_q_o` is 0 during reset and otherwise equals the `dep_o` of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| old_has_dst_i | input | 1 | Older instruction has a destination operand |
| old_dst_disp_i | input | 1 | Older destination is a displacement (memory) operand |
| old_dst_reg_i | input | REG_W | Older destination register number |
| old_wr_flag_i | input | 1 | Older instruction writes the condition flag |
| new_src_kind_i | input | 2*NUM_SRC | Kind of each newer source slot (slot i at bits 2i+1:2i) |
| new_src_reg_i | input | REG_W*NUM_SRC | Register number of each newer source slot |
| new_dst_disp_i | input | 1 | Newer instruction has a displacement destination |
| new_dst_reg_i | input | REG_W | Base register of the newer displacement destination |
| new_rd_flag_i | input | 1 | Newer instruction reads the condition flag |
| dep_o | output | 1 | Combinational dependency |
| dep_q_o | output | 1 | Registered copy of dep_o |

## Verification
Two conditions can raise `dep_o` in the same cycle:

- the flag conflict (older instruction writes the flag, newer one reads it);
- a register or displacement conflict.

The bench provokes both together. It raises the flag bits while a slot matches the older destination, and again while the older instruction has no destination at all. Its behavioural model ORs the two causes independently, so a design that lets one cause mask or gate the other shows up as a mismatch on `dep_o`. The bench also checks `dep_q_o` against the model's value from the cycle before.

// File: rtl/issue_hazard_pkg.sv
package issue_hazard_pkg;
  typedef enum logic [1:0] {
    OPK_NONE = 2'd0,
    OPK_IMM  = 2'd1,
    OPK_REG  = 2'd2,
    OPK_DISP = 2'd3
  } opnd_kind_e;
endpackage

// File: rtl/hazard_slot_cmp.sv
module hazard_slot_cmp
  import issue_hazard_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       kind_i,
  input  logic [REG_W-1:0] reg_i,
  input  logic             old_dst_disp_i,
  input  logic [REG_W-1:0] old_dst_reg_i,
  output logic             hit_o
);
  opnd_kind_e kind;
  logic       uses_reg;
  logic       same_reg;
  logic       old_is_zero;

  assign kind        = opnd_kind_e'(kind_i);
  assign uses_reg    = (kind == OPK_REG) || (kind == OPK_DISP);
  assign same_reg    = (reg_i == old_dst_reg_i);
  assign old_is_zero = (old_dst_reg_i == '0);

  // memory-after-memory always conflicts; register-direct only on real match
  always_comb begin
    if (old_dst_disp_i) hit_o = (kind == OPK_DISP);
    else                hit_o = uses_reg && same_reg && !old_is_zero;
  end

  // R3
  imm_never_hits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'd1 || kind_i == 2'd0) |-> !hit_o);

  // R6
  disp_vs_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (old_dst_disp_i && kind_i == 2'd2) |-> !hit_o);

  // R5
  reg_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!old_dst_disp_i && reg_i == '0) |-> !hit_o);
endmodule

// File: rtl/hazard_reduce.sv
module hazard_reduce #(
  parameter int unsigned NUM_SLOT = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SLOT-1:0] slot_hit_i,
  input  logic                old_has_dst_i,
  input  logic                old_wr_flag_i,
  input  logic                new_rd_flag_i,
  output logic                dep_o
);
  logic flag_dep;
  logic reg_dep;

  assign flag_dep = old_wr_flag_i & new_rd_flag_i;
  assign reg_dep  = old_has_dst_i & (|slot_hit_i);
  assign dep_o    = flag_dep | reg_dep;

  // R1
  flag_dep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (old_wr_flag_i && new_rd_flag_i) |-> dep_o);

  // R2
  no_dst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!old_has_dst_i && !(old_wr_flag_i && new_rd_flag_i)) |-> !dep_o);
endmodule

// File: rtl/issue_hazard_top.sv
module issue_hazard_top
  import issue_hazard_pkg::*;
#(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     old_has_dst_i,
  input  logic                     old_dst_disp_i,
  input  logic [REG_W-1:0]         old_dst_reg_i,
  input  logic                     old_wr_flag_i,
  input  logic [2*NUM_SRC-1:0]     new_src_kind_i,
  input  logic [REG_W*NUM_SRC-1:0] new_src_reg_i,
  input  logic                     new_dst_disp_i,
  input  logic [REG_W-1:0]         new_dst_reg_i,
  input  logic                     new_rd_flag_i,
  output logic                     dep_o,
  output logic                     dep_q_o
);
  // last slot carries the newer instruction's displacement destination
  localparam int unsigned NUM_SLOT = NUM_SRC + 1;

  logic [NUM_SLOT-1:0] slot_hit;
  logic [1:0]          slot_kind [NUM_SLOT];
  logic [REG_W-1:0]    slot_reg  [NUM_SLOT];

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    if (g < NUM_SRC) begin : g_src
      assign slot_kind[g] = new_src_kind_i[2*g +: 2];
      assign slot_reg[g]  = new_src_reg_i[REG_W*g +: REG_W];
    end else begin : g_st_base
      assign slot_kind[g] = new_dst_disp_i ? OPK_DISP : OPK_NONE;
      assign slot_reg[g]  = new_dst_reg_i;
    end

    hazard_slot_cmp #(.REG_W(REG_W)) u_cmp (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .kind_i         (slot_kind[g]),
      .reg_i          (slot_reg[g]),
      .old_dst_disp_i (old_dst_disp_i),
      .old_dst_reg_i  (old_dst_reg_i),
      .hit_o          (slot_hit[g])
    );
  end

  hazard_reduce #(.NUM_SLOT(NUM_SLOT)) u_reduce (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .slot_hit_i    (slot_hit),
    .old_has_dst_i (old_has_dst_i),
    .old_wr_flag_i (old_wr_flag_i),
    .new_rd_flag_i (new_rd_flag_i),
    .dep_o         (dep_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dep_q_o <= 1'b0;
    else         dep_q_o <= dep_o;
  end

  // R9
  dep_q_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (dep_q_o == $past(dep_o)));

  // R7
  mem_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (old_has_dst_i && old_dst_disp_i && new_dst_disp_i) |-> dep_o);
endmodule

// File: tb/issue_hazard_top_bench.sv
module issue_hazard_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;
  localparam int NS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic old_has_dst = 0, old_dst_disp = 0, old_wr_flag = 0;
  logic [RW-1:0] old_dst_reg = '0;
  logic [2*NS-1:0] new_src_kind = '0;
  logic [RW*NS-1:0] new_src_reg = '0;
  logic new_dst_disp = 0, new_rd_flag = 0;
  logic [RW-1:0] new_dst_reg = '0;
  logic dep, dep_q;

  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  issue_hazard_top #(.REG_W(RW), .NUM_SRC(NS)) u_issue_hazard_top (
    .clk_i(clk), .rst_ni(rst_n),
    .old_has_dst_i(old_has_dst), .old_dst_disp_i(old_dst_disp),
    .old_dst_reg_i(old_dst_reg), .old_wr_flag_i(old_wr_flag),
    .new_src_kind_i(new_src_kind), .new_src_reg_i(new_src_reg),
    .new_dst_disp_i(new_dst_disp), .new_dst_reg_i(new_dst_reg),
    .new_rd_flag_i(new_rd_flag), .dep_o(dep), .dep_q_o(dep_q)
  );

  function automatic bit ref_dep();
    bit d;
    int kind [NS+1];
    int rg   [NS+1];
    d = old_wr_flag && new_rd_flag;
    for (int i = 0; i < NS; i++) begin
      kind[i] = int'(new_src_kind[2*i +: 2]);
      rg[i]   = int'(new_src_reg[RW*i +: RW]);
    end
    kind[NS] = new_dst_disp ? 3 : 0;
    rg[NS]   = int'(new_dst_reg);
    if (old_has_dst) begin
      for (int i = 0; i <= NS; i++) begin
        if (old_dst_disp) begin
          if (kind[i] == 3) d = 1;
        end else if ((kind[i] == 2 || kind[i] == 3) && rg[i] == int'(old_dst_reg)
                     && old_dst_reg != 0) begin
          d = 1;
        end
      end
    end
    return d;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic clear();
    old_has_dst = 0; old_dst_disp = 0; old_dst_reg = '0; old_wr_flag = 0;
    new_src_kind = '0; new_src_reg = '0; new_dst_disp = 0; new_dst_reg = '0;
    new_rd_flag = 0;
  endtask

  task automatic set_src(int i, int k, int r);
    new_src_kind[2*i +: 2] = 2'(k);
    new_src_reg[RW*i +: RW] = RW'(r);
  endtask

  // inputs already driven; check comb now, registered copy after the edge
  task automatic step(string tag, logic exp_fixed, bit use_fixed);
    logic e;
    e = ref_dep();
    #2;
    check(tag, dep, use_fixed ? exp_fixed : e);
    @(posedge clk); #1;
    check("R9", dep_q, e);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    clear();
    old_has_dst = 1; old_dst_reg = 5; set_src(0, 2, 5); old_wr_flag = 1; new_rd_flag = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R9", dep_q, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: flag only
    clear(); old_wr_flag = 1; new_rd_flag = 1; step("R1", 1, 1);
    clear(); old_wr_flag = 1; step("R1", 0, 1);
    // R2: no destination, matching register ignored
    clear(); old_dst_reg = 7; set_src(0, 2, 7); new_dst_disp = 1; step("R2", 0, 1);
    old_wr_flag = 1; new_rd_flag = 1; step("R2", 1, 1);
    // R3: immediate/unused slot with matching value
    clear(); old_has_dst = 1; old_dst_reg = 9; set_src(1, 1, 9); set_src(2, 0, 9); step("R3", 0, 1);
    // R4: direct match / mismatch / displacement base match
    clear(); old_has_dst = 1; old_dst_reg = 9; set_src(2, 2, 9); step("R4", 1, 1);
    set_src(2, 2, 8); step("R4", 0, 1);
    set_src(1, 3, 9); step("R4", 1, 1);
    // R5: register zero
    clear(); old_has_dst = 1; old_dst_reg = 0; set_src(0, 2, 0); set_src(1, 3, 0); step("R5", 0, 1);
    // R6: disp dest vs direct source with equal number
    clear(); old_has_dst = 1; old_dst_disp = 1; old_dst_reg = 4; set_src(0, 2, 4); step("R6", 0, 1);
    // R7: disp vs disp, differing registers and register 0
    set_src(1, 3, 17); step("R7", 1, 1);
    set_src(1, 3, 0); old_dst_reg = 0; step("R7", 1, 1);
    // R8: newer store base
    clear(); old_has_dst = 1; old_dst_reg = 12; new_dst_disp = 1; new_dst_reg = 12; step("R8", 1, 1);
    new_dst_reg = 13; step("R8", 0, 1);
    new_dst_disp = 0; new_dst_reg = 12; step("R8", 0, 1);
    clear(); old_has_dst = 1; old_dst_disp = 1; new_dst_disp = 1; new_dst_reg = 3; step("R8", 1, 1);
    // both causes together
    clear(); old_has_dst = 1; old_dst_reg = 6; set_src(0, 2, 6); old_wr_flag = 1; new_rd_flag = 1;
    step("R1", 1, 1);

    // random sweep against the model
    for (int n = 0; n < 3000; n++) begin
      old_has_dst  = 1'($urandom);
      old_dst_disp = 1'($urandom);
      old_dst_reg  = RW'($urandom_range(0, 3));
      old_wr_flag  = 1'($urandom);
      new_rd_flag  = 1'($urandom);
      new_dst_disp = 1'($urandom);
      new_dst_reg  = RW'($urandom_range(0, 3));
      for (int i = 0; i < NS; i++) set_src(i, $urandom_range(0, 3), $urandom_range(0, 3));
      step("R4", 0, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule